// File: doc/BRIEF.md
# Receive Frame Page Formatter

This block lays an incoming network frame into one page of a packet buffer, in the layout that receive software expects. A frame begins with a start handshake that carries its byte length. The block then takes the bytes on a valid/ready stream and issues one byte write per cycle to the page that an external allocator grants. The finished page holds four parts: a header with a status word and a byte count, the payload zero-padded to the minimum frame size, an optional CRC-32, and a two-byte trailer that marks whether the length was odd.

A frame is refused in four cases: receive is disabled, soft reset is held, the page image would be larger than the page, or the allocator has no free page. A refused frame is still taken from the stream so that the next frame lines up, but nothing is written. When the last header byte is written, the page number goes to the receive queue and a receive interrupt request is raised.

Top module: `rx_frame_fmt`

## Requirements
- R1: A frame is refused when `rx_en_i` is 0 or `soft_rst_i` is 1 at its start. In that case `drop_o` pulses once, no allocation is requested, nothing is written, nothing is pushed, and all of the frame's bytes are still accepted.
- R2: Let P be 64 for lengths below 64, and otherwise the length rounded down to even. The byte count is P + 6, plus 4 when `strip_crc_i` is 0. A frame whose byte count exceeds 2048 is refused as in R1.
- R3: When `alloc_grant_i` is 0 in the cycle of `alloc_req_o`, the frame is refused: `drop_o` pulses, and there are no writes and no push.
- R4: Header: byte 0 holds status bits 7:0 and byte 1 holds bits 15:8. Status bit 11 is set when the length exceeds 1518, bit 12 is set when the length is odd, and every other bit is 0. Byte 2 holds the byte count bits 7:0 and byte 3 holds bits 15:8.
- R5: Payload byte i (length at least 1) goes to address 4+i. Frames shorter than 64 bytes are padded with zero bytes up to address 67, and a short odd frame keeps its last byte at its own place.
- R6: When `strip_crc_i` is 0, the reflected CRC-32 (polynomial 0xEDB88320, all-ones preset, inverted result) over the padded frame (all bytes for lengths of 64 or more) is written at 4+P, least significant byte first.
- R7: The trailer sits at 4+P, or at 4+P+4 when the CRC is kept. For an odd length of 64 or more it is the last payload byte followed by 0x60. Otherwise it is 0x00 followed by 0x40.
- R8: An accepted frame makes exactly byte-count writes, one per cycle at most, all to the granted page. Payload, padding, CRC and trailer are written in ascending address order, and the four header bytes (addresses 0..3) are written last.
- R9: `rxq_push_o` and `rcv_irq_o` pulse together once per accepted frame, in the cycle of the header write to address 3, with `rxq_page_o` equal to the granted page.
- R10: `start_ready_o` is high only while idle, and `in_ready_o` is high only while a frame's bytes are being taken. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| soft_rst_i | input | 1 | Soft reset active; refuses frames |
| strip_crc_i | input | 1 | 1 = do not store CRC |
| start_valid_i | input | 1 | Frame start request |
| start_len_i | input | LEN_W | Frame length in bytes (at least 1) |
| start_ready_o | output | 1 | Start accepted |
| in_valid_i | input | 1 | Byte valid |
| in_data_i | input | 8 | Byte value |
| in_last_i | input | 1 | Final byte of the frame |
| in_ready_o | output | 1 | Byte accepted |
| alloc_req_o | output | 1 | Page request to allocator |
| alloc_grant_i | input | 1 | Same-cycle grant |
| alloc_page_i | input | PAGE_W | Granted page number |
| wr_en_o | output | 1 | Buffer byte write strobe |
| wr_page_o | output | PAGE_W | Page being written |
| wr_addr_o | output | ADDR_W | Byte address in page |
| wr_data_o | output | 8 | Byte written |
| rxq_push_o | output | 1 | Push page to receive queue |
| rxq_page_o | output | PAGE_W | Page pushed |
| rcv_irq_o | output | 1 | Receive interrupt request pulse |
| drop_o | output | 1 | Frame refused |

## Verification
The hardest cases to reach sit on the byte-count limit, where one extra byte, or a change to the CRC setting, decides between a full 2048-byte page and a refusal. The stimulus sends frames of 2039 and 2040 bytes with the CRC kept, and 2043 and 2044 bytes with it stripped. Odd lengths on both sides of 64 are paired with both CRC settings, so that the held final byte lands after the CRC, after the payload, or in place inside the padding. A bench model predicts every write address and byte and compares them on each clock.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PAY, ST_DROP, ST_PAD, ST_CRC, ST_TRL, ST_HDR
  } rxf_state_e;

  localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
  localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
  localparam int          HDR_BYTES  = 4;
  localparam int          CRC_BYTES  = 4;
  localparam int          TRL_BYTES  = 2;
  localparam logic [7:0]  CTL_ODD    = 8'h60;
  localparam logic [7:0]  CTL_EVEN   = 8'h40;
  localparam int          STAT_LONG  = 11;
  localparam int          STAT_ODD   = 12;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxf_crc32.sv
`timescale 1ns/1ps
module rxf_crc32 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  import rxf_pkg::*;
  logic [31:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= CRC_PRESET;
    else if (clr_i) acc_q <= CRC_PRESET;
    else if (en_i)  acc_q <= crc_step(acc_q, data_i);
  end

  assign crc_o = ~acc_q;
endmodule

// File: rtl/rxf_plan.sv
`timescale 1ns/1ps
module rxf_plan #(
  parameter int LEN_W      = 12,
  parameter int CNT_W      = 13,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LEN   = 1518,
  parameter int PAGE_BYTES = 2048
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             strip_i,
  output logic [CNT_W-1:0] pad_len_o,
  output logic [CNT_W-1:0] count_o,
  output logic             short_o,
  output logic             odd_o,
  output logic             long_o,
  output logic             oversize_o
);
  import rxf_pkg::*;
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] LONG_C = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] PAGE_C = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] FIX_C  = CNT_W'(HDR_BYTES + TRL_BYTES);
  localparam logic [CNT_W-1:0] CRC_C  = CNT_W'(CRC_BYTES);

  logic [CNT_W-1:0] len_c;
  assign len_c      = CNT_W'(len_i);
  assign short_o    = len_c < MIN_C;
  assign odd_o      = len_i[0];
  assign long_o     = len_c > LONG_C;
  assign pad_len_o  = short_o ? MIN_C : {len_c[CNT_W-1:1], 1'b0};
  assign count_o    = pad_len_o + FIX_C + (strip_i ? '0 : CRC_C);
  assign oversize_o = count_o > PAGE_C;
endmodule

// File: rtl/rxf_ctrl.sv
`timescale 1ns/1ps
module rxf_ctrl #(
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 13,
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 2,
  parameter int MIN_FRAME = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              soft_rst_i,
  input  logic              strip_i,
  input  logic              start_valid_i,
  input  logic [LEN_W-1:0]  start_len_i,
  output logic              start_ready_o,
  input  logic [CNT_W-1:0]  pad_len_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              short_i,
  input  logic              odd_i,
  input  logic              long_i,
  input  logic              oversize_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              alloc_req_o,
  input  logic              alloc_grant_i,
  input  logic [PAGE_W-1:0] alloc_page_i,
  input  logic [31:0]       crc_res_i,
  output logic              crc_clr_o,
  output logic              crc_en_o,
  output logic [7:0]        crc_dat_o,
  output logic              wr_en_o,
  output logic [PAGE_W-1:0] wr_page_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rxq_push_o,
  output logic [PAGE_W-1:0] rxq_page_o,
  output logic              rcv_irq_o,
  output logic              drop_o
);
  import rxf_pkg::*;
  localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] CRC_C = CNT_W'(CRC_BYTES);
  localparam logic [LEN_W-1:0] PAD_END = LEN_W'(MIN_FRAME - 1);

  rxf_state_e        st_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [CNT_W-1:0]  pad_q, cnt_q;
  logic              short_q, odd_q, long_q, keep_q;
  logic [PAGE_W-1:0] page_q;
  logic [1:0]        sub_q;
  logic [7:0]        held_q;

  logic cfg_block, last_idx, odd_long;
  logic [CNT_W-1:0] addr_c, idx_c;
  logic [15:0] status_w, count_w;

  assign cfg_block = !rx_en_i || soft_rst_i || oversize_i;
  assign last_idx  = idx_q == len_q - LEN_W'(1);
  assign odd_long  = odd_q && !short_q;
  assign idx_c     = CNT_W'(idx_q);

  always_comb begin
    status_w = '0;
    status_w[STAT_LONG] = long_q;
    status_w[STAT_ODD]  = odd_q;
  end
  assign count_w = 16'(cnt_q);

  assign start_ready_o = st_q == ST_IDLE;
  assign in_ready_o    = (st_q == ST_PAY) || (st_q == ST_DROP);
  assign alloc_req_o   = start_ready_o && start_valid_i && !cfg_block;
  assign drop_o        = start_ready_o && start_valid_i && (cfg_block || !alloc_grant_i);
  assign crc_clr_o     = st_q == ST_IDLE;
  assign wr_page_o     = page_q;
  assign rxq_page_o    = page_q;
  assign rxq_push_o    = (st_q == ST_HDR) && (sub_q == 2'd3);
  assign rcv_irq_o     = rxq_push_o;
  assign wr_addr_o     = addr_c[ADDR_W-1:0];

  always_comb begin
    wr_en_o   = 1'b0;
    addr_c    = '0;
    wr_data_o = 8'h00;
    crc_en_o  = 1'b0;
    crc_dat_o = 8'h00;
    unique case (st_q)
      ST_PAY: begin
        crc_en_o  = in_valid_i;
        crc_dat_o = in_data_i;
        wr_en_o   = in_valid_i && !(odd_long && last_idx);
        addr_c    = HDR_C + idx_c;
        wr_data_o = in_data_i;
      end
      ST_PAD: begin
        crc_en_o = 1'b1;
        wr_en_o  = 1'b1;
        addr_c   = HDR_C + idx_c;
      end
      ST_CRC: begin
        wr_en_o   = 1'b1;
        addr_c    = HDR_C + pad_q + CNT_W'(sub_q);
        wr_data_o = crc_res_i[8*sub_q +: 8];
      end
      ST_TRL: begin
        wr_en_o = 1'b1;
        addr_c  = HDR_C + pad_q + (keep_q ? CRC_C : '0) + CNT_W'(sub_q);
        if (sub_q[0]) wr_data_o = odd_long ? CTL_ODD : CTL_EVEN;
        else          wr_data_o = odd_long ? held_q : 8'h00;
      end
      ST_HDR: begin
        wr_en_o = 1'b1;
        addr_c  = CNT_W'(sub_q);
        unique case (sub_q)
          2'd0: wr_data_o = status_w[7:0];
          2'd1: wr_data_o = status_w[15:8];
          2'd2: wr_data_o = count_w[7:0];
          default: wr_data_o = count_w[15:8];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; len_q <= '0; idx_q <= '0; pad_q <= '0; cnt_q <= '0;
      short_q <= 1'b0; odd_q <= 1'b0; long_q <= 1'b0; keep_q <= 1'b0;
      page_q <= '0; sub_q <= '0; held_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_valid_i) begin
          len_q <= start_len_i; idx_q <= '0; sub_q <= '0;
          pad_q <= pad_len_i; cnt_q <= count_i;
          short_q <= short_i; odd_q <= odd_i; long_q <= long_i; keep_q <= !strip_i;
          if (cfg_block || !alloc_grant_i) begin
            st_q <= (start_len_i != '0) ? ST_DROP : ST_IDLE;
          end else begin
            page_q <= alloc_page_i;
            st_q   <= (start_len_i != '0) ? ST_PAY : ST_PAD;
          end
        end
        ST_PAY: if (in_valid_i) begin
          idx_q <= idx_q + LEN_W'(1);
          if (last_idx) begin
            if (odd_long) held_q <= in_data_i;
            st_q <= short_q ? ST_PAD : (keep_q ? ST_CRC : ST_TRL);
          end
        end
        ST_DROP: if (in_valid_i) begin
          idx_q <= idx_q + LEN_W'(1);
          if (last_idx) st_q <= ST_IDLE;
        end
        ST_PAD: begin
          idx_q <= idx_q + LEN_W'(1);
          if (idx_q == PAD_END) st_q <= keep_q ? ST_CRC : ST_TRL;
        end
        ST_CRC: begin
          sub_q <= sub_q + 2'd1;
          if (sub_q == 2'd3) st_q <= ST_TRL;
        end
        ST_TRL: begin
          sub_q <= sub_q[0] ? 2'd0 : 2'd1;
          if (sub_q[0]) st_q <= ST_HDR;
        end
        ST_HDR: begin
          sub_q <= sub_q + 2'd1;
          if (sub_q == 2'd3) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_ready_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_ready_o && in_ready_o));
  assert_push_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxq_push_o |=> !rxq_push_o);
  assert_page_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && st_q != ST_PAY) |=> (!wr_en_o || $stable(wr_page_o)));
  assert_last_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |-> last_idx);
endmodule

// File: rtl/rx_frame_fmt.sv
`timescale 1ns/1ps
module rx_frame_fmt #(
  parameter int PAGE_BYTES = 2048,
  parameter int LEN_W      = 12,
  parameter int PAGE_W     = 2,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LEN   = 1518,
  localparam int ADDR_W    = $clog2(PAGE_BYTES),
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              soft_rst_i,
  input  logic              strip_crc_i,
  input  logic              start_valid_i,
  input  logic [LEN_W-1:0]  start_len_i,
  output logic              start_ready_o,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              alloc_req_o,
  input  logic              alloc_grant_i,
  input  logic [PAGE_W-1:0] alloc_page_i,
  output logic              wr_en_o,
  output logic [PAGE_W-1:0] wr_page_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rxq_push_o,
  output logic [PAGE_W-1:0] rxq_page_o,
  output logic              rcv_irq_o,
  output logic              drop_o
);
  logic [CNT_W-1:0] pad_len, count;
  logic short_f, odd_f, long_f, oversize;
  logic crc_clr, crc_en;
  logic [7:0] crc_dat;
  logic [31:0] crc_res;

  rxf_plan #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME),
             .LONG_LEN(LONG_LEN), .PAGE_BYTES(PAGE_BYTES)) u_plan (
    .len_i(start_len_i), .strip_i(strip_crc_i), .pad_len_o(pad_len),
    .count_o(count), .short_o(short_f), .odd_o(odd_f), .long_o(long_f),
    .oversize_o(oversize));

  rxf_crc32 u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(crc_clr), .en_i(crc_en),
    .data_i(crc_dat), .crc_o(crc_res));

  rxf_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
             .MIN_FRAME(MIN_FRAME)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .soft_rst_i(soft_rst_i),
    .strip_i(strip_crc_i), .start_valid_i(start_valid_i), .start_len_i(start_len_i),
    .start_ready_o(start_ready_o), .pad_len_i(pad_len), .count_i(count),
    .short_i(short_f), .odd_i(odd_f), .long_i(long_f), .oversize_i(oversize),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .alloc_req_o(alloc_req_o), .alloc_grant_i(alloc_grant_i),
    .alloc_page_i(alloc_page_i), .crc_res_i(crc_res), .crc_clr_o(crc_clr),
    .crc_en_o(crc_en), .crc_dat_o(crc_dat), .wr_en_o(wr_en_o), .wr_page_o(wr_page_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .rxq_push_o(rxq_push_o),
    .rxq_page_o(rxq_page_o), .rcv_irq_o(rcv_irq_o), .drop_o(drop_o));

  assert_no_alloc_oversize_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_o |-> !oversize);
  assert_drop_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (!wr_en_o && !rxq_push_o));
  assert_push_on_hdr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxq_push_o |-> (wr_en_o && wr_addr_o == ADDR_W'(3)));
  assert_rejected_cfg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_valid_i && start_ready_o && (!rx_en_i || soft_rst_i)) |-> (drop_o && !alloc_req_o));
endmodule

// File: tb/rx_frame_fmt_bench.sv
`timescale 1ns/1ps
module rx_frame_fmt_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rx_en, soft_rst, strip_crc;
  logic start_valid; logic [11:0] start_len; logic start_ready;
  logic in_valid; logic [7:0] in_data; logic in_last; logic in_ready;
  logic alloc_req, alloc_grant; logic [1:0] alloc_page;
  logic wr_en; logic [1:0] wr_page; logic [10:0] wr_addr; logic [7:0] wr_data;
  logic rxq_push; logic [1:0] rxq_page; logic rcv_irq; logic drop;

  rx_frame_fmt u_rx_frame_fmt (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .soft_rst_i(soft_rst),
    .strip_crc_i(strip_crc), .start_valid_i(start_valid), .start_len_i(start_len),
    .start_ready_o(start_ready), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_ready_o(in_ready), .alloc_req_o(alloc_req),
    .alloc_grant_i(alloc_grant), .alloc_page_i(alloc_page), .wr_en_o(wr_en),
    .wr_page_o(wr_page), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rxq_push_o(rxq_push), .rxq_page_o(rxq_page), .rcv_irq_o(rcv_irq), .drop_o(drop));

  int checks = 0, errors = 0;
  int exp_addr[$]; int exp_data[$]; string exp_tag[$];
  int exp_page, got_push, got_drop, got_req;
  logic [7:0] fr [0:4095];

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [7:0] b);
    logic [31:0] r; logic fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ b[k];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the write port against the predicted write list
  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (exp_addr.size() == 0) check(0, "R8 unexpected write", int'(wr_addr), -1);
      else begin
        int ea, ed; string t;
        ea = exp_addr.pop_front(); ed = exp_data.pop_front(); t = exp_tag.pop_front();
        check(int'(wr_addr) == ea, "R8 write address", int'(wr_addr), ea);
        check(int'(wr_data) == ed, t, int'(wr_data), ed);
        check(int'(wr_page) == exp_page, "R8 write page", int'(wr_page), exp_page);
      end
    end
    if (rxq_push) begin
      got_push++;
      check(rcv_irq == 1'b1, "R9 irq with push", int'(rcv_irq), 1);
      check(int'(rxq_page) == exp_page, "R9 pushed page", int'(rxq_page), exp_page);
      check(exp_addr.size() == 0, "R9 push on last write", exp_addr.size(), 0);
    end
    if (drop) got_drop++;
    if (alloc_req) got_req++;
  end

  task automatic expect_wr(int a, int d, string t);
    exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic run_frame(int len, int seed, bit en, bit srst, bit strip, bit grant, int page);
    int n, p, cnt, tb_, exp_push, exp_drop, exp_req;
    bit odd, oddlong, refuse_cfg;
    logic [31:0] c;
    for (int i = 0; i < 4096; i++) fr[i] = (i < len) ? 8'((i * 7 + seed) & 255) : 8'h00;
    odd = len[0];
    oddlong = odd && len >= 64;
    p = (len < 64) ? 64 : (len & ~1);
    cnt = p + 6 + (strip ? 0 : 4);
    refuse_cfg = !en || srst || cnt > 2048;
    exp_req  = refuse_cfg ? 0 : 1;
    exp_drop = (refuse_cfg || !grant) ? 1 : 0;
    exp_push = 1 - exp_drop;
    exp_page = page;
    if (exp_push == 1) begin
      for (int i = 0; i < len; i++)
        if (!(oddlong && i == len - 1)) expect_wr(4 + i, fr[i], "R5 payload");
      for (int i = len; i < 64; i++) expect_wr(4 + i, 0, "R5 padding");
      n = (len < 64) ? 64 : len;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) c = ref_crc(c, fr[i]);
      c = ~c;
      if (!strip) for (int k = 0; k < 4; k++) expect_wr(4 + p + k, int'((c >> (8 * k)) & 32'hFF), "R6 crc");
      tb_ = 4 + p + (strip ? 0 : 4);
      expect_wr(tb_, oddlong ? fr[len - 1] : 0, "R7 trailer byte");
      expect_wr(tb_ + 1, oddlong ? 8'h60 : 8'h40, "R7 control byte");
      expect_wr(0, 0, "R4 status lo");
      expect_wr(1, (odd ? 8'h10 : 8'h00) | (len > 1518 ? 8'h08 : 8'h00), "R4 status hi");
      expect_wr(2, cnt & 255, "R4 count lo");
      expect_wr(3, cnt >> 8, "R4 count hi");
    end
    got_push = 0; got_drop = 0; got_req = 0;
    @(posedge clk); #1;
    rx_en = en; soft_rst = srst; strip_crc = strip; alloc_grant = grant; alloc_page = 2'(page);
    start_valid = 1'b1; start_len = 12'(len);
    do @(negedge clk); while (!start_ready);
    @(posedge clk); #1;
    start_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i % 5 == 3) begin in_valid = 1'b0; @(posedge clk); #1; end
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == len - 1);
      do @(negedge clk); while (!in_ready);
      if (i == 0) check(start_ready == 1'b0, "R10 start ready low in frame", int'(start_ready), 0);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
    for (int w = 0; w < 300; w++) begin
      @(negedge clk);
      if (start_ready && exp_addr.size() == 0) break;
    end
    @(negedge clk);
    check(got_push == exp_push, "R9 push count", got_push, exp_push);
    check(got_drop == exp_drop, exp_req == 0 ? "R1 R2 refusal" : "R3 refusal", got_drop, exp_drop);
    check(got_req == exp_req, "R2 alloc request", got_req, exp_req);
    check(exp_addr.size() == 0, "R8 all writes made", exp_addr.size(), 0);
    check(in_ready == 1'b0 && start_ready == 1'b1, "R10 idle handshakes",
          int'({in_ready, start_ready}), 1);
    exp_addr.delete(); exp_data.delete(); exp_tag.delete();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] c;
    rst_n = 1'b0; rx_en = 1'b1; soft_rst = 1'b0; strip_crc = 1'b0;
    start_valid = 1'b0; start_len = '0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    alloc_grant = 1'b1; alloc_page = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(start_ready == 1'b1 && in_ready == 1'b0, "R10 reset handshakes", int'({start_ready, in_ready}), 2);
    check(wr_en == 1'b0 && rxq_push == 1'b0 && drop == 1'b0, "R9 reset quiet", int'({wr_en, rxq_push, drop}), 0);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) c = ref_crc(c, 8'(8'h31 + i));
    check(~c == 32'hCBF43926, "R6 reference crc", int'(~c), 32'hCBF43926);

    run_frame(10,   1, 1, 0, 0, 1, 1);   // R5 short even, CRC kept
    run_frame(33,   2, 1, 0, 0, 1, 2);   // R5 R7 short odd
    run_frame(33,   3, 1, 0, 1, 1, 3);   // R7 short odd, stripped
    run_frame(64,   4, 1, 0, 0, 1, 0);   // R6 exact minimum
    run_frame(65,   5, 1, 0, 0, 1, 1);   // R7 odd long, byte after CRC
    run_frame(101,  6, 1, 0, 1, 1, 2);   // R7 odd long, stripped
    run_frame(100,  7, 1, 0, 1, 1, 3);   // R6 stripped even
    run_frame(1519, 8, 1, 0, 0, 1, 0);   // R4 too-long and odd
    run_frame(2039, 9, 1, 0, 0, 1, 1);   // R2 count 2048 accepted
    run_frame(2040, 10, 1, 0, 0, 1, 2);  // R2 count 2050 refused
    run_frame(2043, 11, 1, 0, 1, 1, 3);  // R2 stripped, 2048 accepted
    run_frame(2044, 12, 1, 0, 1, 1, 0);  // R2 stripped, refused
    run_frame(70,   13, 0, 0, 0, 1, 1);  // R1 receive disabled
    run_frame(70,   14, 1, 1, 0, 1, 2);  // R1 soft reset
    run_frame(80,   15, 1, 0, 0, 0, 3);  // R3 no free page
    run_frame(1,    16, 1, 0, 0, 1, 2);  // R5 single byte
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule